// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block is the digital control core that guards a battery-backed memory array during supply loss and recovery. External comparators supply three status flags. The first says the supply is above the switchover level. The second says it is above the write-protect threshold. The third says it is inside the full operating range. Each flag passes through a two-flop synchroniser and a debounce counter. A five-state controller then decides whether the host may reach the array, whether the array runs from the battery, and whether the one-time shipping seal still holds the battery off.

Host chip-enable, write-enable and output-enable pass through a gate before they reach the array. Outside the normal state, every host strobe is held inactive and the data drivers stay off. After a supply dip, the block waits through a long recovery window before it releases protection. If the supply dips during that window, the window starts again from zero. A parameter picks one of two threshold pairs. The tight pair protects near 4.5 V and allows full operation above 4.75 V. The wide pair protects near 4.25 V and allows full operation above 4.5 V. Timers count cycles of a free-running clock that is present whenever either supply source is present.

Top module: `pfwp_sequencer`

## Requirements
- R1: After reset the state is sealed (status 0): `seal_intact`=1 and `bat_sel`=0 whatever the flags say. The first filtered protect-ok flag breaks the seal for good, and no later input returns the block to the sealed state.
- R2: In every state except normal, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1 whatever the host strobes are.
- R3: `dq_drive` is 1 only in the normal state with host chip-enable and output-enable low (0) and host write-enable high (1). In every other case it is 0.
- R4: When the protect-ok flag drops during normal operation, the memory strobes go inactive within 150 clock cycles of the raw flag change.
- R5: The normal state is entered only after at least `REC_CYC` consecutive cycles in the recovering state.
- R6: If the protect-ok flag drops while the block is recovering, the block leaves recovery. The next recovery starts its count from zero.
- R7: The block leaves recovery for normal only while the filtered operating-range flag is 1. With the timer expired and the flag at 0, the block stays in recovery.
- R8: `WIDE_TOL`=0 uses the tight flag pair (`op_hi_tight`, `wp_ok_tight`). `WIDE_TOL`=1 uses the wide pair (`op_hi_wide`, `wp_ok_wide`).
- R9: `bat_sel` is 1 exactly in the battery state (status 1). The block enters that state from any unsealed state when the switchover flag is 0. When the switchover flag returns to 1, the block moves to the protected state (status 2) with `bat_sel`=0.
- R10: A flag excursion that lasts fewer than `DEB_CYCLES` clock cycles changes no state and no output.
- R11: `status` encodes the state: 0 sealed, 1 battery, 2 protected, 3 recovering, 4 normal.
- R12: In the normal state, `mem_ce_n`, `mem_we_n` and `mem_oe_n` equal the host strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset (first power-up) |
| sw_ok | input | 1 | Supply above battery switchover level |
| wp_ok_tight | input | 1 | Supply above protect threshold, tight pair |
| wp_ok_wide | input | 1 | Supply above protect threshold, wide pair |
| op_hi_tight | input | 1 | Supply inside full operating range, tight pair |
| op_hi_wide | input | 1 | Supply inside full operating range, wide pair |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| mem_ce_n | output | 1 | Gated chip enable to the array |
| mem_we_n | output | 1 | Gated write enable to the array |
| mem_oe_n | output | 1 | Gated output enable to the array |
| dq_drive | output | 1 | Data output driver enable |
| wr_block | output | 1 | Write-protect gate active |
| bat_sel | output | 1 | Array powered from battery |
| seal_intact | output | 1 | Shipping seal still holds battery off |
| status | output | 3 | Current state code |

## Verification
The assertions assume that the comparator flags are nested the way a real supply ramp nests them. The operating-range flag is 1 only when the protect flag is 1, and the protect flag is 1 only when the switchover flag is 1. Flags change far more slowly than the debounce window, apart from deliberate chatter. The vector table moves the supply one threshold at a time in both directions and holds each setting long enough to settle. The chatter test breaks the slow-change assumption only with pulses shorter than the debounce window. Host strobes change only between vectors, so the gated outputs are sampled with their inputs already stable.

// File: rtl/pfwp_pkg.sv
`timescale 1ns/1ps
package pfwp_pkg;

    localparam int ST_W = 3;

    // state codes are visible on the status port
    typedef enum logic [ST_W-1:0] {
        PF_SEALED  = 3'd0,
        PF_BATTERY = 3'd1,
        PF_PROTECT = 3'd2,
        PF_RECOVER = 3'd3,
        PF_NORMAL  = 3'd4
    } pf_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

endpackage

// File: rtl/pfwp_flag_filter.sv
`timescale 1ns/1ps
module pfwp_flag_filter #(
    parameter int DEB_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_raw,
    output logic flag_flt
);
    localparam int CW = $clog2(DEB_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    typedef struct packed {
        logic          meta;
        logic          sync;
        logic          flt;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t filt_d, filt_q;

    always_comb begin
        filt_d      = filt_q;
        filt_d.meta = flag_raw;
        filt_d.sync = filt_q.meta;
        if (filt_q.sync != filt_q.flt) begin
            if (filt_q.cnt == LAST) begin
                filt_d.flt = filt_q.sync;
                filt_d.cnt = '0;
            end else begin
                filt_d.cnt = filt_q.cnt + 1'b1;
            end
        end else begin
            filt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) filt_q <= '0;
        else        filt_q <= filt_d;
    end

    assign flag_flt = filt_q.flt;

endmodule

// File: rtl/pfwp_ctrl_fsm.sv
`timescale 1ns/1ps
module pfwp_ctrl_fsm
    import pfwp_pkg::*;
#(
    parameter int REC_CYC = 12_500_000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sw_ok,
    input  logic      wp_ok,
    input  logic      op_ok,
    output pf_state_e state
);
    localparam int TW = $clog2(REC_CYC + 1);
    localparam logic [TW-1:0] TMAX = TW'(REC_CYC);

    typedef struct packed {
        pf_state_e     st;
        logic [TW-1:0] tmr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            PF_SEALED: begin
                // battery stays off until protect level is first seen
                if (wp_ok) begin
                    ctl_d.st  = PF_RECOVER;
                    ctl_d.tmr = '0;
                end
            end
            PF_BATTERY: begin
                if (sw_ok) ctl_d.st = PF_PROTECT;
            end
            PF_PROTECT: begin
                if (!sw_ok) begin
                    ctl_d.st = PF_BATTERY;
                end else if (wp_ok) begin
                    ctl_d.st  = PF_RECOVER;
                    ctl_d.tmr = '0;
                end
            end
            PF_RECOVER: begin
                if (!sw_ok) begin
                    ctl_d.st = PF_BATTERY;
                end else if (!wp_ok) begin
                    ctl_d.st = PF_PROTECT;
                end else if (ctl_q.tmr == TMAX) begin
                    if (op_ok) ctl_d.st = PF_NORMAL;
                end else begin
                    ctl_d.tmr = ctl_q.tmr + 1'b1;
                end
            end
            PF_NORMAL: begin
                if (!sw_ok)      ctl_d.st = PF_BATTERY;
                else if (!wp_ok) ctl_d.st = PF_PROTECT;
            end
            default: ctl_d.st = PF_PROTECT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st  <= PF_SEALED;
            ctl_q.tmr <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state = ctl_q.st;

endmodule

// File: rtl/pfwp_access_gate.sv
`timescale 1ns/1ps
module pfwp_access_gate
    import pfwp_pkg::*;
(
    input  pf_state_e state,
    input  strobe_t   host,
    output strobe_t   mem,
    output logic      dq_drive,
    output logic      wr_block,
    output logic      bat_sel,
    output logic      seal_intact
);
    logic blk;

    always_comb begin
        blk         = (state != PF_NORMAL);
        mem.ce_n    = host.ce_n | blk;
        mem.we_n    = host.we_n | blk;
        mem.oe_n    = host.oe_n | blk;
        dq_drive    = !blk && !host.ce_n && !host.oe_n && host.we_n;
        wr_block    = blk;
        bat_sel     = (state == PF_BATTERY);
        seal_intact = (state == PF_SEALED);
    end

endmodule

// File: rtl/pfwp_sequencer.sv
`timescale 1ns/1ps
module pfwp_sequencer
    import pfwp_pkg::*;
#(
    parameter bit WIDE_TOL   = 1'b0,
    parameter int DEB_CYCLES = 4,
    parameter int REC_CYC    = 12_500_000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_ok,
    input  logic            wp_ok_tight,
    input  logic            wp_ok_wide,
    input  logic            op_hi_tight,
    input  logic            op_hi_wide,
    input  logic            host_ce_n,
    input  logic            host_we_n,
    input  logic            host_oe_n,
    output logic            mem_ce_n,
    output logic            mem_we_n,
    output logic            mem_oe_n,
    output logic            dq_drive,
    output logic            wr_block,
    output logic            bat_sel,
    output logic            seal_intact,
    output logic [ST_W-1:0] status
);
    localparam int NFLAG = 3;

    logic [NFLAG-1:0] raw_flags, flt_flags;
    logic             flt_sw, flt_wp, flt_op;
    pf_state_e        state;
    strobe_t          host_s, mem_s;

    // pick the threshold pair once, at elaboration
    assign raw_flags = WIDE_TOL ? {op_hi_wide,  wp_ok_wide,  sw_ok}
                                : {op_hi_tight, wp_ok_tight, sw_ok};

    for (genvar g = 0; g < NFLAG; g++) begin : g_filt
        pfwp_flag_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .flag_raw (raw_flags[g]),
            .flag_flt (flt_flags[g])
        );
    end

    assign flt_sw = flt_flags[0];
    assign flt_wp = flt_flags[1];
    assign flt_op = flt_flags[2];

    pfwp_ctrl_fsm #(.REC_CYC(REC_CYC)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .sw_ok (flt_sw),
        .wp_ok (flt_wp),
        .op_ok (flt_op),
        .state (state)
    );

    assign host_s = '{ce_n: host_ce_n, we_n: host_we_n, oe_n: host_oe_n};

    pfwp_access_gate u_gate (
        .state       (state),
        .host        (host_s),
        .mem         (mem_s),
        .dq_drive    (dq_drive),
        .wr_block    (wr_block),
        .bat_sel     (bat_sel),
        .seal_intact (seal_intact)
    );

    assign mem_ce_n = mem_s.ce_n;
    assign mem_we_n = mem_s.we_n;
    assign mem_oe_n = mem_s.oe_n;
    assign status   = state;

endmodule

// File: rtl/pfwp_sequencer_chk.sv
`timescale 1ns/1ps
module pfwp_sequencer_chk
    import pfwp_pkg::*;
#(
    parameter int REC_CYC = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [ST_W-1:0] status,
    input logic            mem_ce_n,
    input logic            mem_we_n,
    input logic            mem_oe_n,
    input logic            dq_drive,
    input logic            bat_sel,
    input logic            seal_intact,
    input logic            wp_ok_f,
    input logic            op_ok_f
);
    logic [31:0] rec_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   rec_run <= '0;
        else if (status == PF_RECOVER) rec_run <= (rec_run == '1) ? rec_run : rec_run + 1'b1;
        else                          rec_run <= '0;
    end

    // R1
    seal_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status != PF_SEALED) |=> (status != PF_SEALED));

    // R1
    seal_no_batt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bat_sel |-> !seal_intact);

    // R2
    strobe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status != PF_NORMAL) |-> (mem_ce_n && mem_we_n && mem_oe_n));

    // R3
    dq_only_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> (status == PF_NORMAL));

    // R4
    fail_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_ok_f |=> (mem_we_n && mem_ce_n));

    // R5
    recover_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status == PF_NORMAL) |-> (rec_run >= 32'(REC_CYC)));

    // R7
    op_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status == PF_NORMAL) |-> $past(op_ok_f));

    // R9
    batt_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bat_sel |-> (status == PF_BATTERY));

endmodule

bind pfwp_sequencer pfwp_sequencer_chk #(.REC_CYC(REC_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .status      (status),
    .mem_ce_n    (mem_ce_n),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .dq_drive    (dq_drive),
    .bat_sel     (bat_sel),
    .seal_intact (seal_intact),
    .wp_ok_f     (flt_wp),
    .op_ok_f     (flt_op)
);

// File: tb/pfwp_sequencer_bench.sv
`timescale 1ns/1ps
module pfwp_sequencer_bench;

    localparam int REC = 100;
    localparam int DEB = 4;
    localparam int NV  = 19;

    // flags = {op_tight, op_wide, wp_tight, wp_wide, sw}
    typedef struct packed {
        logic [4:0] flg;
        logic       ce, we, oe;
        logic [7:0] wt;
        logic [2:0] st, stw;
        logic       mwe, mce, dq, bat, seal;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{5'b00000, 1'b1,1'b1,1'b1, 8'd20,  3'd0,3'd0, 1'b1,1'b1,1'b0,1'b0,1'b1},
        '{5'b00001, 1'b1,1'b1,1'b1, 8'd20,  3'd0,3'd0, 1'b1,1'b1,1'b0,1'b0,1'b1},
        '{5'b00011, 1'b1,1'b1,1'b1, 8'd20,  3'd0,3'd3, 1'b1,1'b1,1'b0,1'b0,1'b1},
        '{5'b01111, 1'b1,1'b1,1'b1, 8'd20,  3'd3,3'd3, 1'b1,1'b1,1'b0,1'b0,1'b0},
        '{5'b01111, 1'b1,1'b1,1'b1, 8'd150, 3'd3,3'd4, 1'b1,1'b1,1'b0,1'b0,1'b0},
        '{5'b11111, 1'b1,1'b1,1'b1, 8'd20,  3'd4,3'd4, 1'b1,1'b1,1'b0,1'b0,1'b0},
        '{5'b11111, 1'b0,1'b0,1'b1, 8'd2,   3'd4,3'd4, 1'b0,1'b0,1'b0,1'b0,1'b0},
        '{5'b11111, 1'b0,1'b1,1'b0, 8'd2,   3'd4,3'd4, 1'b1,1'b0,1'b1,1'b0,1'b0},
        '{5'b00001, 1'b0,1'b1,1'b0, 8'd20,  3'd2,3'd2, 1'b1,1'b1,1'b0,1'b0,1'b0},
        '{5'b00001, 1'b0,1'b0,1'b1, 8'd2,   3'd2,3'd2, 1'b1,1'b1,1'b0,1'b0,1'b0},
        '{5'b00000, 1'b1,1'b1,1'b1, 8'd20,  3'd1,3'd1, 1'b1,1'b1,1'b0,1'b1,1'b0},
        '{5'b00001, 1'b1,1'b1,1'b1, 8'd20,  3'd2,3'd2, 1'b1,1'b1,1'b0,1'b0,1'b0},
        '{5'b11111, 1'b1,1'b1,1'b1, 8'd50,  3'd3,3'd3, 1'b1,1'b1,1'b0,1'b0,1'b0},
        '{5'b00001, 1'b1,1'b1,1'b1, 8'd20,  3'd2,3'd2, 1'b1,1'b1,1'b0,1'b0,1'b0},
        '{5'b11111, 1'b1,1'b1,1'b1, 8'd40,  3'd3,3'd3, 1'b1,1'b1,1'b0,1'b0,1'b0},
        '{5'b11111, 1'b1,1'b1,1'b1, 8'd40,  3'd3,3'd3, 1'b1,1'b1,1'b0,1'b0,1'b0},
        '{5'b11111, 1'b1,1'b1,1'b1, 8'd60,  3'd4,3'd4, 1'b1,1'b1,1'b0,1'b0,1'b0},
        '{5'b00000, 1'b1,1'b1,1'b1, 8'd20,  3'd1,3'd1, 1'b1,1'b1,1'b0,1'b1,1'b0},
        '{5'b11111, 1'b1,1'b1,1'b1, 8'd130, 3'd4,3'd4, 1'b1,1'b1,1'b0,1'b0,1'b0}
    };
    // rows 3-4: timer expired but tight range flag low, stays recovering (R7)
    // row 4: wide instance reaches normal with the same inputs (R8)
    // rows 12-16: dip during recovery restarts the window (R6); rows 16,18 need the full window (R5)
    // rows 17-18: from normal straight to battery and back, never sealed again (R1, R9)

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] flags = '0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;

    logic mce, mwe, moe, dqd, wrb, bat, seal;
    logic [2:0] st;
    logic mce_w, mwe_w, moe_w, dqd_w, wrb_w, bat_w, seal_w;
    logic [2:0] st_w;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pfwp_sequencer #(.WIDE_TOL(1'b0), .DEB_CYCLES(DEB), .REC_CYC(REC)) u_pfwp_sequencer (
        .clk(clk), .rst_n(rst_n),
        .sw_ok(flags[0]), .wp_ok_wide(flags[1]), .wp_ok_tight(flags[2]),
        .op_hi_wide(flags[3]), .op_hi_tight(flags[4]),
        .host_ce_n(ce_n), .host_we_n(we_n), .host_oe_n(oe_n),
        .mem_ce_n(mce), .mem_we_n(mwe), .mem_oe_n(moe), .dq_drive(dqd),
        .wr_block(wrb), .bat_sel(bat), .seal_intact(seal), .status(st)
    );

    pfwp_sequencer #(.WIDE_TOL(1'b1), .DEB_CYCLES(DEB), .REC_CYC(REC)) u_pfwp_sequencer_wide (
        .clk(clk), .rst_n(rst_n),
        .sw_ok(flags[0]), .wp_ok_wide(flags[1]), .wp_ok_tight(flags[2]),
        .op_hi_wide(flags[3]), .op_hi_tight(flags[4]),
        .host_ce_n(ce_n), .host_we_n(we_n), .host_oe_n(oe_n),
        .mem_ce_n(mce_w), .mem_we_n(mwe_w), .mem_oe_n(moe_w), .dq_drive(dqd_w),
        .wr_block(wrb_w), .bat_sel(bat_w), .seal_intact(seal_w), .status(st_w)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state (R1, R11)
        chk("R11 reset status", int'(st), 0);
        chk("R1 reset seal", int'(seal), 1);
        chk("R2 reset we gate", int'(mwe), 1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            flags = TBL[i].flg;
            ce_n  = TBL[i].ce;
            we_n  = TBL[i].we;
            oe_n  = TBL[i].oe;
            repeat (int'(TBL[i].wt)) @(negedge clk);
            chk($sformatf("R11 status v%0d", i), int'(st), int'(TBL[i].st));
            chk($sformatf("R8 wide status v%0d", i), int'(st_w), int'(TBL[i].stw));
            chk($sformatf("R2 mem_we_n v%0d", i), int'(mwe), int'(TBL[i].mwe));
            chk($sformatf("R12 mem_ce_n v%0d", i), int'(mce), int'(TBL[i].mce));
            chk($sformatf("R3 dq_drive v%0d", i), int'(dqd), int'(TBL[i].dq));
            chk($sformatf("R9 bat_sel v%0d", i), int'(bat), int'(TBL[i].bat));
            chk($sformatf("R1 seal v%0d", i), int'(seal), int'(TBL[i].seal));
        end

        // chatter shorter than the debounce window (R10)
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        for (int k = 0; k < 10; k++) begin
            flags = 5'b00000;
            repeat (DEB - 2) @(negedge clk);
            flags = 5'b11111;
            repeat (6) @(negedge clk);
            chk("R10 chatter status", int'(st), 4);
        end
        chk("R10 chatter bat_sel", int'(bat), 0);

        // fail-to-gate latency (R4)
        ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        chk("R12 write passes in normal", int'(mwe), 0);
        begin
            int lat = 0;
            flags = 5'b00001;
            while (mwe == 1'b0 && lat < 1000) begin
                @(negedge clk);
                lat++;
            end
            chk("R4 gate within limit", int'(lat <= 150), 1);
        end
        chk("R2 write held off", int'(mce), 1);

        ce_n = 1'b1; we_n = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule